// File: doc/BRIEF.md
# Programmable Asynchronous Memory Controller

This block runs single read and write accesses on an external asynchronous memory or peripheral bus: SRAM, NOR flash or a memory-mapped device. A host issues one request at a time on a valid/ready port. The controller then drives select, output-enable, write-enable, direction, bank and word address lines through three timed phases: address setup, strobe and hold. Every phase length comes from a configuration input and is counted in controller clocks. Reads and writes have separate phase settings. A read returns its data together with a one-clock completion pulse.

An optional extended-wait mode lets a slow device stretch the strobe by holding a wait line. That line passes through a two-flop synchronizer, and a configuration bit sets its active level. A programmable limit caps the stretch. When the limit is hit, the strobe ends anyway and a sticky error flag is raised until the host clears it. A select-strobe option makes chip select follow the strobe instead of framing the whole access. After every read, idle turnaround clocks hold off the next access so that the memory can release the data bus.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are high, mem_dout_en and done are low, req_ready is high and wait_err is low.
- R2: Every phase field holds its length minus one (setup 4 bits, strobe 6 bits, hold 3 bits, turnaround 2 bits, wait limit 8 bits). A read with no waits lasts setup + strobe + hold clocks from the acceptance edge to the clock in which done is high, and done is high for exactly one clock.
- R3: A write with no waits lasts write setup + write strobe + write hold clocks, measured the same way as in R2.
- R4: mem_oe_n is low only in read strobe clocks and mem_we_n only in write strobe clocks, each for exactly the strobe length plus any wait extension; the two are never low together.
- R5: mem_addr, mem_ba and mem_rnw (1 = read, 0 = write) hold the request's values in every clock from the first setup clock to the last hold clock.
- R6: With cfg_sel_strobe = 0, mem_cs_n is low for every setup, strobe and hold clock. With cfg_sel_strobe = 1, mem_cs_n is low exactly in the strobe clocks.
- R7: With cfg_ext_wait = 1, an active synchronized wait on the last programmed strobe clock adds one strobe clock. cfg_wait_pol = 1 means mem_wait is active high, and 0 means active low. With cfg_ext_wait = 0, mem_wait has no effect on strobe length.
- R8: When the wait input goes inactive during an extended strobe, the strobe ends at the third rising clock edge after the change.
- R9: A strobe is extended by at most cfg_max_wait + 1 clocks. When that limit is reached, the strobe ends and wait_err is set. wait_err stays high until err_clear is pulsed.
- R10: Read data is sampled from mem_din on the last strobe clock and is presented on rdata while done is high.
- R11: mem_dout_en is high only from the first write setup clock to the last write hold clock, and mem_dout then equals the request's write data.
- R12: After a read, req_ready stays low for cfg_turn + 1 clocks, starting with the clock in which done is high. After a write, req_ready is already high in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_bank | input | BANK_W | Bank address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle and accepting |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Read data |
| cfg_rsetup | input | SETUP_W | Read setup length minus one |
| cfg_rstrobe | input | STROBE_W | Read strobe length minus one |
| cfg_rhold | input | HOLD_W | Read hold length minus one |
| cfg_wsetup | input | SETUP_W | Write setup length minus one |
| cfg_wstrobe | input | STROBE_W | Write strobe length minus one |
| cfg_whold | input | HOLD_W | Write hold length minus one |
| cfg_turn | input | TURN_W | Turnaround length minus one |
| cfg_max_wait | input | MAXW_W | Wait extension limit minus one |
| cfg_ext_wait | input | 1 | Enable strobe extension by mem_wait |
| cfg_wait_pol | input | 1 | 1 = mem_wait active high |
| cfg_sel_strobe | input | 1 | Chip select follows the strobe |
| err_clear | input | 1 | Clears wait_err |
| wait_err | output | 1 | Sticky wait timeout flag |
| mem_wait | input | 1 | Device wait request, asynchronous |
| mem_din | input | DATA_W | Data from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rnw | output | 1 | Direction, 1 = read |
| mem_ba | output | BANK_W | Bank address |
| mem_addr | output | ADDR_W | Word address |
| mem_dout | output | DATA_W | Data to memory |
| mem_dout_en | output | 1 | Data bus drive enable |

## Verification
The hardest behaviour to reach from the ports is the end of a stretched strobe. Its timing depends on the synchronizer latency and on the exact strobe clock in which the wait line goes inactive. To get there, the bench asserts the wait level before the request is issued, so the synchronizer is already settled. It then releases the line on a chosen strobe clock, counted from the observed strobe pins, and compares the strobe length with the release clock plus two. The timeout path is reached by holding wait active through the whole access. Both polarities are covered, and wait is also held active with extension disabled, which must leave the strobe untouched.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_e;

  // Length in clocks encoded by a configuration field (field holds length - 1)
  function automatic logic [15:0] phase_len(input logic [15:0] code);
    return code + 16'd1;
  endfunction

  // Largest of four widths, used to size the shared phase counter
  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/asram_wait_sync.sv
`timescale 1ns/1ps
module asram_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/asram_phase_fsm.sv
`timescale 1ns/1ps
module asram_phase_fsm
  import asram_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int MAXW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_wr,
  input  logic              ext_en,
  input  logic              wait_act,
  input  logic              err_clear,
  input  logic [CNT_W-1:0]  setup_code,
  input  logic [CNT_W-1:0]  strobe_code,
  input  logic [CNT_W-1:0]  hold_code,
  input  logic [CNT_W-1:0]  turn_code,
  input  logic [MAXW_W-1:0] max_wait_code,
  output phase_e            phase,
  output logic              strobe_last,
  output logic              wait_extend,
  output logic              wait_timeout,
  output logic              done,
  output logic              wait_err
);
  localparam int WCNT_W = MAXW_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [WCNT_W-1:0] wcnt;
  logic [WCNT_W-1:0] wait_limit;
  logic              cnt_zero;
  logic              strobe_end_chk;
  logic              wait_hit;

  assign wait_limit     = WCNT_W'(phase_len(16'(max_wait_code)));
  assign cnt_zero       = (cnt == '0);
  assign strobe_end_chk = (phase == PH_STROBE) && cnt_zero;
  assign wait_hit       = strobe_end_chk && ext_en && wait_act;
  assign wait_extend    = wait_hit && (wcnt < wait_limit);
  assign wait_timeout   = wait_hit && !(wcnt < wait_limit);
  assign strobe_last    = strobe_end_chk && !wait_extend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      wcnt     <= '0;
      done     <= 1'b0;
      wait_err <= 1'b0;
    end else begin
      done <= (phase == PH_HOLD) && cnt_zero;
      if (wait_timeout)   wait_err <= 1'b1;
      else if (err_clear) wait_err <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= setup_code;
          wcnt  <= '0;
        end
        PH_SETUP: if (cnt_zero) begin
          phase <= PH_STROBE;
          cnt   <= strobe_code;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (!cnt_zero) cnt <= cnt - 1'b1;
          else if (wait_extend) wcnt <= wcnt + 1'b1;
          else begin
            phase <= PH_HOLD;
            cnt   <= hold_code;
          end
        PH_HOLD: if (cnt_zero) begin
          phase <= is_wr ? PH_IDLE : PH_TURN;
          cnt   <= turn_code;
        end else cnt <= cnt - 1'b1;
        PH_TURN: if (cnt_zero) phase <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BANK_W      = 2,
  parameter int DATA_W      = 16,
  parameter int SETUP_W     = 4,
  parameter int STROBE_W    = 6,
  parameter int HOLD_W      = 3,
  parameter int TURN_W      = 2,
  parameter int MAXW_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  input  logic [SETUP_W-1:0]  cfg_rsetup,
  input  logic [STROBE_W-1:0] cfg_rstrobe,
  input  logic [HOLD_W-1:0]   cfg_rhold,
  input  logic [SETUP_W-1:0]  cfg_wsetup,
  input  logic [STROBE_W-1:0] cfg_wstrobe,
  input  logic [HOLD_W-1:0]   cfg_whold,
  input  logic [TURN_W-1:0]   cfg_turn,
  input  logic [MAXW_W-1:0]   cfg_max_wait,
  input  logic                cfg_ext_wait,
  input  logic                cfg_wait_pol,
  input  logic                cfg_sel_strobe,
  input  logic                err_clear,
  output logic                wait_err,
  input  logic                mem_wait,
  input  logic [DATA_W-1:0]   mem_din,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_rnw,
  output logic [BANK_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dout,
  output logic                mem_dout_en
);
  localparam int CNT_W = max4(SETUP_W, STROBE_W, HOLD_W, TURN_W);

  phase_e            phase;
  logic              start;
  logic              is_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  setup_code, strobe_code, hold_code, turn_code;
  logic              wait_sync, wait_act;
  logic              in_access, strobe_on;
  // Named internal events observed by the bound checker
  logic              strobe_last, wait_extend, wait_timeout, turn_active;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      bank_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      is_wr_q <= req_write;
      addr_q  <= req_addr;
      bank_q  <= req_bank;
      wdata_q <= req_wdata;
    end
  end

  // Setup length is chosen from the incoming request; later phases from the latched one
  assign setup_code  = req_write ? CNT_W'(cfg_wsetup)  : CNT_W'(cfg_rsetup);
  assign strobe_code = is_wr_q   ? CNT_W'(cfg_wstrobe) : CNT_W'(cfg_rstrobe);
  assign hold_code   = is_wr_q   ? CNT_W'(cfg_whold)   : CNT_W'(cfg_rhold);
  assign turn_code   = CNT_W'(cfg_turn);

  asram_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (mem_wait),
    .sync_out (wait_sync)
  );
  assign wait_act = cfg_wait_pol ? wait_sync : !wait_sync;

  asram_phase_fsm #(.CNT_W(CNT_W), .MAXW_W(MAXW_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .is_wr         (is_wr_q),
    .ext_en        (cfg_ext_wait),
    .wait_act      (wait_act),
    .err_clear     (err_clear),
    .setup_code    (setup_code),
    .strobe_code   (strobe_code),
    .hold_code     (hold_code),
    .turn_code     (turn_code),
    .max_wait_code (cfg_max_wait),
    .phase         (phase),
    .strobe_last   (strobe_last),
    .wait_extend   (wait_extend),
    .wait_timeout  (wait_timeout),
    .done          (done),
    .wait_err      (wait_err)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       rdata_q <= '0;
    else if (strobe_last && !is_wr_q) rdata_q <= mem_din;

  assign in_access   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe_on   = (phase == PH_STROBE);
  assign turn_active = (phase == PH_TURN);

  assign mem_cs_n    = cfg_sel_strobe ? !strobe_on : !in_access;
  assign mem_oe_n    = !(strobe_on && !is_wr_q);
  assign mem_we_n    = !(strobe_on && is_wr_q);
  assign mem_rnw     = !is_wr_q;
  assign mem_ba      = bank_q;
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_dout_en = in_access && is_wr_q;
  assign rdata       = rdata_q;
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              err_clear,
  input logic              wait_err,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_rnw,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dout_en,
  input logic              wait_extend,
  input logic              wait_timeout,
  input logic              turn_active
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  assert_cs_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  assert_extend_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_extend |=> (!mem_oe_n || !mem_we_n));

  assert_timeout_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_timeout |=> (mem_oe_n && mem_we_n && wait_err));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_err && !err_clear) |=> wait_err);

  assert_dout_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> !mem_rnw);

  assert_turn_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    turn_active |-> !req_ready);
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [1:0]  req_bank = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done, wait_err;
  logic [15:0] rdata;
  logic [3:0]  cfg_rsetup = 4'd2, cfg_wsetup = 4'd0;
  logic [5:0]  cfg_rstrobe = 6'd4, cfg_wstrobe = 6'd2;
  logic [2:0]  cfg_rhold = 3'd1, cfg_whold = 3'd3;
  logic [1:0]  cfg_turn = 2'd2;
  logic [7:0]  cfg_max_wait = 8'd255;
  logic        cfg_ext_wait = 1'b0, cfg_wait_pol = 1'b1, cfg_sel_strobe = 1'b0;
  logic        err_clear = 1'b0, mem_wait = 1'b0;
  logic [15:0] din_model = 16'hA5C3;
  logic [15:0] mem_din;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_rnw, mem_dout_en;
  logic [1:0]  mem_ba;
  logic [13:0] mem_addr;
  logic [15:0] mem_dout;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_total, m_pre, m_strb, m_post, m_cs_bad, m_bus_bad, m_dout_bad, m_turn;
  logic [15:0] m_rdata;
  logic m_ready_at_done, m_done_after, m_err_at_done;

  always #5 clk = ~clk;
  assign mem_din = mem_oe_n ? 16'h0000 : din_model;

  asram_ctrl uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one access and measure every clock of it at the negative edge
  task automatic do_access(input logic wr, input logic [13:0] a, input logic [1:0] b,
                           input logic [15:0] wd, input int drop_at);
    bit strobe_now, exp_cs;
    int guard;
    m_total = 0; m_pre = 0; m_strb = 0; m_post = 0;
    m_cs_bad = 0; m_bus_bad = 0; m_dout_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_bank = b; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_bank = ~b; req_wdata = ~wd;
    guard = 0;
    while (!done && guard < 2000) begin
      guard++;
      m_total++;
      strobe_now = !mem_oe_n || !mem_we_n;
      if (strobe_now) begin
        m_strb++;
        if (wr && !mem_oe_n) m_bus_bad++;
        if (!wr && !mem_we_n) m_bus_bad++;
        if (drop_at != 0 && m_strb == drop_at) mem_wait = cfg_wait_pol ? 1'b0 : 1'b1;
      end else if (m_strb == 0) m_pre++;
      else m_post++;
      exp_cs = cfg_sel_strobe ? !strobe_now : 1'b0;
      if (mem_cs_n != exp_cs) m_cs_bad++;
      if (mem_addr != a || mem_ba != b || mem_rnw != !wr) m_bus_bad++;
      if (mem_dout_en != wr || (wr && mem_dout != wd)) m_dout_bad++;
      @(negedge clk);
    end
    m_rdata = rdata;
    m_err_at_done = wait_err;
    m_ready_at_done = req_ready;
    m_turn = req_ready ? 0 : 1;
    @(negedge clk);
    m_done_after = done;
    while (!req_ready && m_turn < 100) begin
      m_turn++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dout_en && !done, "R1 dout_en/done low", {mem_dout_en, done}, 0);
    chk(req_ready && !wait_err, "R1 ready high, err low", {req_ready, wait_err}, 2);
  endtask

  task automatic t_read_basic;
    // R2: setup 3, strobe 5, hold 2; turnaround 3
    do_access(1'b0, 14'h1234, 2'd2, 16'h0, 0);
    chk(m_total == 10, "R2 read length", m_total, 10);
    chk(!m_done_after, "R2 done one clock", m_done_after, 0);
    chk(m_strb == 5, "R4 read strobe length", m_strb, 5);
    chk(m_pre == 3 && m_post == 2, "R5 setup/hold lead and trail", m_pre * 10 + m_post, 32);
    chk(m_bus_bad == 0, "R5 address/bank/direction held", m_bus_bad, 0);
    chk(m_cs_bad == 0, "R6 select framing", m_cs_bad, 0);
    chk(m_rdata == 16'hA5C3, "R10 read data", m_rdata, 16'hA5C3);
    chk(m_turn == 3, "R12 read turnaround", m_turn, 3);
    chk(m_dout_bad == 0, "R11 no drive on read", m_dout_bad, 0);
  endtask

  task automatic t_write_basic;
    // R3: setup 1, strobe 3, hold 4
    do_access(1'b1, 14'h0ABC, 2'd1, 16'h5A0F, 0);
    chk(m_total == 8, "R3 write length", m_total, 8);
    chk(m_strb == 3 && m_bus_bad == 0, "R4 write strobe", m_strb, 3);
    chk(m_dout_bad == 0, "R11 write data drive", m_dout_bad, 0);
    chk(m_ready_at_done && m_turn == 0, "R12 no turnaround after write", m_turn, 0);
    chk(!mem_dout_en, "R11 drive released when idle", mem_dout_en, 0);
  endtask

  task automatic t_sel_strobe;
    cfg_sel_strobe = 1'b1;
    do_access(1'b0, 14'h0011, 2'd3, 16'h0, 0);
    chk(m_cs_bad == 0, "R6 select follows strobe (read)", m_cs_bad, 0);
    do_access(1'b1, 14'h0022, 2'd0, 16'h1111, 0);
    chk(m_cs_bad == 0 && m_strb == 3, "R6 select follows strobe (write)", m_cs_bad, 0);
    cfg_sel_strobe = 1'b0;
  endtask

  task automatic t_wait_ignored;
    cfg_ext_wait = 1'b0; cfg_wait_pol = 1'b1; mem_wait = 1'b1;
    repeat (4) @(negedge clk);
    do_access(1'b0, 14'h0100, 2'd0, 16'h0, 0);
    chk(m_strb == 5 && m_total == 10, "R7 wait ignored when disabled", m_strb, 5);
    mem_wait = 1'b0;
  endtask

  task automatic t_wait_release;
    // R8: strobe 2, wait high, released on strobe clock 4 -> 6 strobe clocks
    cfg_ext_wait = 1'b1; cfg_wait_pol = 1'b1; cfg_rstrobe = 6'd1; mem_wait = 1'b1;
    repeat (4) @(negedge clk);
    do_access(1'b0, 14'h0200, 2'd1, 16'h0, 4);
    chk(m_strb == 6, "R8 strobe ends third edge after release", m_strb, 6);
    chk(m_total == 3 + 6 + 2, "R7 extension lengthens cycle", m_total, 11);
    chk(m_rdata == 16'hA5C3, "R10 data at end of stretched strobe", m_rdata, 16'hA5C3);
    chk(!wait_err, "R9 no error without timeout", wait_err, 0);
  endtask

  task automatic t_wait_low_pol;
    // R7: active-low wait on a write; strobe 3, released on strobe clock 3 -> 5
    cfg_wait_pol = 1'b0; mem_wait = 1'b0;
    repeat (4) @(negedge clk);
    do_access(1'b1, 14'h0300, 2'd2, 16'hBEEF, 3);
    chk(m_strb == 5, "R7 active-low wait extends write strobe", m_strb, 5);
    chk(m_dout_bad == 0, "R11 data held through extension", m_dout_bad, 0);
    mem_wait = 1'b1;
  endtask

  task automatic t_timeout;
    // R9: strobe 3, limit 4, wait never released -> strobe 7, error set
    cfg_wait_pol = 1'b1; mem_wait = 1'b1; cfg_rstrobe = 6'd2; cfg_max_wait = 8'd3;
    repeat (4) @(negedge clk);
    do_access(1'b0, 14'h0400, 2'd3, 16'h0, 0);
    chk(m_strb == 7, "R9 strobe capped by limit", m_strb, 7);
    chk(m_err_at_done, "R9 error raised", m_err_at_done, 1);
    mem_wait = 1'b0;
    repeat (3) @(negedge clk);
    chk(wait_err, "R9 error sticky", wait_err, 1);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    chk(!wait_err, "R9 error cleared", wait_err, 0);
    cfg_ext_wait = 1'b0; cfg_max_wait = 8'd255; cfg_rstrobe = 6'd4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read_basic();
    t_write_basic();
    t_sel_strobe();
    t_wait_ignored();
    t_wait_release();
    t_wait_low_pol();
    t_timeout();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule